// File: doc/BRIEF.md
# Packed Byte Window and Shuffle Unit

This block rearranges the bytes of 128-bit operands. It has two operations. The window operation joins operand `a` and operand `b` into one double-width value and takes a run of result bytes starting at a byte offset given by `imm`. The shuffle operation builds each result byte from one byte of `a`, picked by a control byte in `b`, or forces that byte to zero. Each operation also runs in a half-width form on the low 64 bits of the operands.

Operations arrive on a valid/ready input stream and leave on a valid/ready output stream. One output register sits between them. `in_ready` is high when that register is empty or is being drained in the same cycle (`!out_valid || out_ready`). An operation is accepted on a rising edge where `in_valid && in_ready`. While `out_valid` is high and `out_ready` is low, the held result and its valid do not change. A new operation is refused until the downstream side takes the held result.

Top module: `bsu_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid` is low and `in_ready` is high. The reset is synchronous.
- R2: An operation is accepted on a rising edge where `in_valid && in_ready`, and `in_ready` equals `!out_valid || out_ready`. The result appears with `out_valid` high after that same edge. Results leave in the order they were accepted, each exactly once.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged on the following edge.
- R4: `op` = 2'b00 is the wide window. The value {a, b}, with `a` in bits 255:128, is shifted right by `imm`×8 bits, and its low 128 bits are the result. With `imm` = 0 the result equals `b`, and with `imm` = 16 it equals `a`.
- R5: In the wide window, offsets 17 to 31 fill the top result bytes with zero. Any offset of 32 or more gives an all-zero result.
- R6: `op` = 2'b01 is the wide shuffle. The control byte for result byte k is `b[8k+7:8k]`. When bit 7 of a control byte is set, result byte k is zero.
- R7: In the wide shuffle, when bit 7 of the control byte is clear, result byte k is byte `ctl[3:0]` of `a`. Control bits 6:4 do not affect the result.
- R8: `op` = 2'b10 is the narrow window. The value {a[63:0], b[63:0]} is shifted right by `imm` bytes, and its low 64 bits form `out_data[63:0]`. An offset of 16 or more gives zero, `out_data[127:64]` is zero, and `a[127:64]` and `b[127:64]` are ignored.
- R9: `op` = 2'b11 is the narrow shuffle. Control byte k, for k from 0 to 7, is `b[8k+7:8k]`. Bit 7 set gives zero. Otherwise the result byte is byte `ctl[2:0]` of `a[63:0]`, and bits 6:3 are ignored. `out_data[127:64]` is zero, and the upper operand halves are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the input |
| in_ready | output | 1 | Unit can accept an operation this cycle |
| op | input | 2 | Operation select: 00 wide window, 01 wide shuffle, 10 narrow window, 11 narrow shuffle |
| imm | input | 8 | Byte offset for the window operations |
| a | input | 128 | First operand (upper half of window / shuffle source) |
| b | input | 128 | Second operand (lower half of window / shuffle controls) |
| out_valid | output | 1 | Result held on `out_data` |
| out_ready | input | 1 | Downstream takes the result this cycle |
| out_data | output | 128 | Registered result |

## Verification
Every result is due one rising edge after its operation is accepted. After that it stays on `out_data` until a rising edge at which `out_ready` is high. The bench drives inputs and sets `out_ready` at the falling edge. It decides whether an operation was accepted from `in_ready` sampled just before the rising edge, and only then puts the expected value in the queue. The monitor compares the head of the queue in the half cycle before the edge that will transfer the result. Under a stall it instead checks that the value held at the previous falling edge is still present.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
  // Operation encodings: bit 1 picks the narrow lane width, bit 0 picks shuffle.
  typedef enum logic [1:0] {
    BSU_WIN_WIDE  = 2'b00,
    BSU_SHF_WIDE  = 2'b01,
    BSU_WIN_NARROW = 2'b10,
    BSU_SHF_NARROW = 2'b11
  } bsu_op_e;

  localparam int BSU_LANE_VARIANTS = 2;

  function automatic logic bsu_is_shuffle(input bsu_op_e o);
    return o[0];
  endfunction

  function automatic int bsu_lane_sel(input bsu_op_e o);
    return o[1] ? 1 : 0;
  endfunction
endpackage

// File: rtl/bsu_window.sv
// Extracts NB bytes from a 2*NB byte concatenation starting at a byte offset.
module bsu_window #(
  parameter int NB = 16,
  parameter int BW = 8,
  parameter int SW = 8
) (
  input  logic [2*NB*BW-1:0] cat_i,
  input  logic [SW-1:0]      shift_i,
  output logic [NB*BW-1:0]   win_o
);
  localparam int TOT = 2 * NB;
  localparam int IW  = $clog2(TOT);
  localparam logic [SW:0] TOT_X = (SW + 1)'(TOT);

  logic [BW-1:0] cat_b [TOT];

  for (genvar i = 0; i < TOT; i++) begin : g_split
    assign cat_b[i] = cat_i[i*BW +: BW];
  end

  for (genvar j = 0; j < NB; j++) begin : g_byte
    localparam logic [SW:0] JX = (SW + 1)'(j);
    logic [SW:0] pos;
    always_comb begin
      pos = {1'b0, shift_i} + JX;
      if (pos < TOT_X) win_o[j*BW +: BW] = cat_b[pos[IW-1:0]];
      else             win_o[j*BW +: BW] = '0;
    end
  end
endmodule

// File: rtl/bsu_shuffle.sv
// Per-byte selection: each control byte either zeroes its result byte or
// names the source byte to copy; only the low log2(NB) bits name it.
module bsu_shuffle #(
  parameter int NB = 16,
  parameter int BW = 8
) (
  input  logic [NB*BW-1:0] src_i,
  input  logic [NB*BW-1:0] ctl_i,
  output logic [NB*BW-1:0] res_o
);
  localparam int SELW = $clog2(NB);

  logic [BW-1:0] src_b [NB];

  for (genvar i = 0; i < NB; i++) begin : g_split
    assign src_b[i] = src_i[i*BW +: BW];
  end

  for (genvar k = 0; k < NB; k++) begin : g_byte
    logic [BW-1:0] ctl;
    logic          unused_rsv;
    assign ctl        = ctl_i[k*BW +: BW];
    assign unused_rsv = ^ctl[BW-2:SELW];
    assign res_o[k*BW +: BW] = ctl[BW-1] ? '0 : src_b[ctl[SELW-1:0]];
  end
endmodule

// File: rtl/bsu_top.sv
module bsu_top #(
  parameter int NBYTES = 16,
  parameter int BW     = 8,
  parameter int IMMW   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [1:0]           op,
  input  logic [IMMW-1:0]      imm,
  input  logic [NBYTES*BW-1:0] a,
  input  logic [NBYTES*BW-1:0] b,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [NBYTES*BW-1:0] out_data
);
  import bsu_pkg::*;

  localparam int W  = NBYTES * BW;
  localparam int HW = W / 2;
  localparam int NV = BSU_LANE_VARIANTS;

  bsu_op_e         op_e;
  logic [W-1:0]    win_res [NV];
  logic [W-1:0]    shf_res [NV];
  logic [W-1:0]    res_next;
  logic            fire;

  assign op_e = bsu_op_e'(op);

  // Lane variant g works on NBYTES >> g bytes of the low operand bits.
  for (genvar g = 0; g < NV; g++) begin : g_lane
    localparam int LB = NBYTES >> g;
    localparam int LW = LB * BW;
    logic [2*LW-1:0] cat;
    logic [LW-1:0]   win;
    logic [LW-1:0]   shf;

    assign cat = {a[LW-1:0], b[LW-1:0]};

    bsu_window #(.NB(LB), .BW(BW), .SW(IMMW)) u_win (
      .cat_i  (cat),
      .shift_i(imm),
      .win_o  (win)
    );

    bsu_shuffle #(.NB(LB), .BW(BW)) u_shf (
      .src_i(a[LW-1:0]),
      .ctl_i(b[LW-1:0]),
      .res_o(shf)
    );

    assign win_res[g] = W'(win);
    assign shf_res[g] = W'(shf);
  end

  always_comb begin
    if (bsu_is_shuffle(op_e)) res_next = shf_res[bsu_lane_sel(op_e)];
    else                      res_next = win_res[bsu_lane_sel(op_e)];
  end

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= res_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Checks kept beside the output stage.
  logic all_clear;
  always_comb begin
    all_clear = 1'b1;
    for (int k = 0; k < NBYTES; k++) all_clear = all_clear & b[k*BW + BW - 1];
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid); // R1

  AST_FIRE_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R2

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R3

  AST_FAR_WINDOW_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 2'b00 && imm >= IMMW'(2*NBYTES)) |=> (out_data == '0)); // R5

  AST_SHUF_ALL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (fire && op == 2'b01 && all_clear) |=> (out_data == '0)); // R6

  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (fire && op[1]) |=> (out_data[W-1:HW] == '0)); // R8, R9
endmodule

// File: tb/tb_bsu_top.sv
module tb_bsu_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [1:0]   op = 2'b00;
  logic [7:0]   imm = 8'd0;
  logic [127:0] a = '0;
  logic [127:0] b = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;

  int checks = 0;
  int failures = 0;
  int rdy_mode = 0;
  bit mon_en = 0;
  logic [127:0] exp_q [$];
  string        tag_q [$];

  always #4 clk = ~clk;

  bsu_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .imm(imm), .a(a), .b(b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] model(input logic [1:0] o, input logic [127:0] x,
                                         input logic [127:0] y, input logic [7:0] n);
    logic [255:0] c256;
    logic [127:0] c128;
    logic [127:0] r;
    logic [7:0]   c;
    r = '0;
    case (o)
      2'b00: begin c256 = {x, y} >> (int'(n) * 8); r = c256[127:0]; end
      2'b10: begin c128 = {x[63:0], y[63:0]} >> (int'(n) * 8); r = {64'd0, c128[63:0]}; end
      2'b01: for (int k = 0; k < 16; k++) begin
               c = y[k*8 +: 8];
               r[k*8 +: 8] = c[7] ? 8'h00 : x[c[3:0]*8 +: 8];
             end
      default: for (int k = 0; k < 8; k++) begin
               c = y[k*8 +: 8];
               r[k*8 +: 8] = c[7] ? 8'h00 : x[c[2:0]*8 +: 8];
             end
    endcase
    return r;
  endfunction

  function automatic string tag_for(input logic [1:0] o, input logic [127:0] y, input logic [7:0] n);
    bit any_sel = 0;
    for (int k = 0; k < 16; k++) if (!y[k*8+7]) any_sel = 1;
    case (o)
      2'b00:   return (n >= 8'd16) ? "R5" : "R4";
      2'b01:   return any_sel ? "R7" : "R6";
      2'b10:   return "R8";
      default: return "R9";
    endcase
  endfunction

  // Driver: pushes the expected result once the operation is accepted.
  task automatic send(input logic [1:0] o, input logic [127:0] x, input logic [127:0] y, input logic [7:0] n);
    bit acc;
    @(negedge clk);
    op = o; a = x; b = y; imm = n; in_valid = 1'b1;
    do begin
      #2 acc = in_ready;
      @(posedge clk);
      if (acc) begin
        exp_q.push_back(model(o, x, y, n));
        tag_q.push_back(tag_for(o, y, n));
      end else @(negedge clk);
    end while (!acc);
    #1 in_valid = 1'b0;
  endtask

  // Monitor: sets out_ready, then checks the item that the next edge transfers.
  logic [127:0] hold_data;
  bit           hold_pending = 0;
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en) begin
        out_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
        #1;
        if (hold_pending)
          chk(out_valid && out_data == hold_data, "R3", out_data, hold_data);
        hold_pending = out_valid && !out_ready;
        hold_data    = out_data;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) chk(0, "R2", out_data, '0);
          else begin
            logic [127:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(out_data == e, t, out_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    chk(0, "watchdog", '0, '0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    logic [127:0] ra, rb, ctl;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1", 128'(out_valid), 128'(0));
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1", {126'd0, out_valid, in_ready}, 128'd1);
    mon_en = 1;

    ra = 128'hF0E0D0C0B0A09080_7060504030201000;
    rb = 128'h0F0E0D0C0B0A0908_0706050403020100;
    // R4 window offsets, R5 far offsets
    send(2'b00, ra, rb, 8'd0);
    send(2'b00, ra, rb, 8'd16);
    send(2'b00, ra, rb, 8'd5);
    send(2'b00, ra, rb, 8'd20);
    send(2'b00, ra, rb, 8'd31);
    send(2'b00, ra, rb, 8'd32);
    send(2'b00, ra, rb, 8'd255);
    // R7 identity, reversal, reserved bits set; R6 all cleared
    send(2'b01, ra, rb, 8'd0);
    for (int k = 0; k < 16; k++) ctl[k*8 +: 8] = 8'(15 - k);
    send(2'b01, ra, ctl, 8'd0);
    for (int k = 0; k < 16; k++) ctl[k*8 +: 8] = 8'h70 | 8'(k);
    send(2'b01, ra, ctl, 8'd0);
    send(2'b01, ra, {16{8'h80}}, 8'd0);
    for (int k = 0; k < 16; k++) ctl[k*8 +: 8] = (k % 2 == 1) ? 8'hFF : 8'h03;
    send(2'b01, ra, ctl, 8'd0);
    // R8 narrow window with junk in the upper halves
    send(2'b10, ra, rb, 8'd3);
    send(2'b10, ra, rb, 8'd8);
    send(2'b10, ra, rb, 8'd15);
    send(2'b10, ra, rb, 8'd16);
    // R9 narrow shuffle, bit 3 and reserved bits set
    for (int k = 0; k < 16; k++) ctl[k*8 +: 8] = 8'h78 | 8'(7 - (k % 8));
    send(2'b11, ra, ctl, 8'd0);
    send(2'b11, ra, {16{8'h85}}, 8'd0);

    // Random traffic with back-pressure (R2, R3)
    rdy_mode = 1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] n;
      ra = rnd128();
      rb = rnd128();
      n  = ($urandom % 2 == 0) ? 8'($urandom % 40) : 8'($urandom);
      send(2'($urandom), ra, rb, n);
    end

    rdy_mode = 0;
    for (int i = 0; i < 50 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && out_valid == 1'b0, "R2", 128'(exp_q.size()), 128'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule